// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator with APB Access

This block gathers a build-time number of level-sensitive interrupt lines (from 2 to 64) and merges them into one request line toward a processor or an upstream controller. Each line passes through two software controls of opposite sense: an enable bit that must be one, and a mask bit that must be zero. Only a line that is high, enabled and unmasked shows up in the final status and contributes to the merged request.

Software reaches the block through an APB slave with no wait states. The enable, mask and final-status registers each come as a pair of 32-bit words: lines 0 to 31 in the low word and lines 32 to 63 in the high word, with the high word 4 bytes above the low one. Positions at or beyond the configured line count have no storage and read as zero, so software can find the line count by writing all ones to the enables and reading them back. A read-only word also reports the lowest-numbered pending line, so a handler can service lines in ascending order without scanning the status bits itself.

Top module: `apb_irq_collector`

## Requirements
- R1: After reset, the enable and mask words all read zero, both status words read zero, the index word reads 0x8000_0000 and `irq_o` is low.
- R2: Enable words sit at offsets 0x00 (lines 0-31) and 0x04 (lines 32-63); a written bit reads back, and bits at positions at or beyond `SRC_COUNT` read zero even after all ones are written.
- R3: Mask words sit at offsets 0x08 (low) and 0x0C (high), read back like the enables (unimplemented positions read zero), and a mask bit of one removes its line from the status.
- R4: Status words at offsets 0x30 (low) and 0x34 (high) show bit n set exactly when line n is high, its enable bit is one and its mask bit is zero.
- R5: Lines are level-sensitive: a status bit follows its input with no latching, and it clears as soon as the input drops; there is no clear register.
- R6: `irq_o` equals the OR of all status bits as it stood one clock earlier.
- R7: The word at offset 0x40 holds the index of the lowest pending line in bits 5:0 with all other bits zero, or exactly 0x8000_0000 when no line is pending.
- R8: Reads of any offset outside the seven listed return zero, and writes to the status words, the index word or unlisted offsets change no register.
- R9: Every transfer completes in its access phase: `pready` is high and `pslverr` is low.
- R10: A register changes only on a write access phase (`psel`, `penable` and `pwrite` all high); a setup phase alone writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, zero outside a read |
| pready | output | 1 | Transfer complete, always high |
| pslverr | output | 1 | Transfer error, always low |
| irq_src_i | input | SRC_COUNT | Level-sensitive interrupt lines |
| irq_o | output | 1 | Merged interrupt request, registered |

## Verification
The checker watches on every cycle that a status bit never appears without its raw line, its enable and a clear mask, that the merged request follows the status OR one cycle later in both directions, that the index word always points at a set status bit with no lower set bit (or shows the idle code), and that the enable and mask storage holds still outside a write access. What only the bench scenarios can show is the address map itself: readback of each word at its offset, zero reads of unimplemented positions and unlisted offsets, and that writes to read-only offsets and setup-only phases leave every readable value unchanged.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

  localparam int unsigned MAX_SRC  = 64;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned IDX_W    = $clog2(MAX_SRC);

  localparam logic [31:0] OFS_ENA_LO  = 32'h00;
  localparam logic [31:0] OFS_ENA_HI  = 32'h04;
  localparam logic [31:0] OFS_MSK_LO  = 32'h08;
  localparam logic [31:0] OFS_MSK_HI  = 32'h0C;
  localparam logic [31:0] OFS_STAT_LO = 32'h30;
  localparam logic [31:0] OFS_STAT_HI = 32'h34;
  localparam logic [31:0] OFS_FIRST   = 32'h40;

  localparam logic [31:0] IDLE_CODE   = 32'h8000_0000;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_ENA_LO,
    SEL_ENA_HI,
    SEL_MSK_LO,
    SEL_MSK_HI,
    SEL_STAT_LO,
    SEL_STAT_HI,
    SEL_FIRST
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [31:0] addr);
    reg_sel_e sel;
    case (addr)
      OFS_ENA_LO:  sel = SEL_ENA_LO;
      OFS_ENA_HI:  sel = SEL_ENA_HI;
      OFS_MSK_LO:  sel = SEL_MSK_LO;
      OFS_MSK_HI:  sel = SEL_MSK_HI;
      OFS_STAT_LO: sel = SEL_STAT_LO;
      OFS_STAT_HI: sel = SEL_STAT_HI;
      OFS_FIRST:   sel = SEL_FIRST;
      default:     sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs
  import irqc_pkg::*;
#(
  parameter int unsigned SRC_COUNT = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stb,
  input  reg_sel_e              wr_sel,
  input  logic [WORD_W-1:0]     wdata,
  output logic [MAX_SRC-1:0]    ena_q,
  output logic [MAX_SRC-1:0]    msk_q
);

  for (genvar g = 0; g < MAX_SRC; g++) begin : g_bit
    localparam bit          IS_HI = (g >= WORD_W);
    localparam int unsigned POS   = g % WORD_W;
    localparam reg_sel_e    ENA_SEL = IS_HI ? SEL_ENA_HI : SEL_ENA_LO;
    localparam reg_sel_e    MSK_SEL = IS_HI ? SEL_MSK_HI : SEL_MSK_LO;

    if (g < SRC_COUNT) begin : g_store
      logic ena_r, ena_d, ena_we;
      logic msk_r, msk_d, msk_we;

      always_comb begin
        ena_we = wr_stb && (wr_sel == ENA_SEL);
        msk_we = wr_stb && (wr_sel == MSK_SEL);
        ena_d  = wdata[POS];
        msk_d  = wdata[POS];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ena_r <= 1'b0;
        end else if (ena_we) begin
          ena_r <= ena_d;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          msk_r <= 1'b0;
        end else if (msk_we) begin
          msk_r <= msk_d;
        end
      end

      assign ena_q[g] = ena_r;
      assign msk_q[g] = msk_r;
    end else begin : g_void
      assign ena_q[g] = 1'b0;
      assign msk_q[g] = 1'b0;
    end
  end

endmodule

// File: rtl/irqc_gate.sv
module irqc_gate
  import irqc_pkg::*;
#(
  parameter int unsigned SRC_COUNT = 40
) (
  input  logic [MAX_SRC-1:0] raw_i,
  input  logic [MAX_SRC-1:0] ena_i,
  input  logic [MAX_SRC-1:0] msk_i,
  output logic [MAX_SRC-1:0] stat_o,
  output logic               any_o
);

  for (genvar g = 0; g < MAX_SRC; g++) begin : g_line
    if (g < SRC_COUNT) begin : g_live
      assign stat_o[g] = raw_i[g] & ena_i[g] & ~msk_i[g];
    end else begin : g_dead
      assign stat_o[g] = 1'b0;
    end
  end

  assign any_o = |stat_o;

endmodule

// File: rtl/irqc_first_set.sv
module irqc_first_set
  import irqc_pkg::*;
(
  input  logic [MAX_SRC-1:0] stat_i,
  output logic [WORD_W-1:0]  first_word_o
);

  logic [IDX_W-1:0] idx;
  logic             hit;

  always_comb begin
    idx = '0;
    hit = 1'b0;
    for (int i = MAX_SRC - 1; i >= 0; i--) begin
      if (stat_i[i]) begin
        idx = IDX_W'(i);
        hit = 1'b1;
      end
    end
  end

  always_comb begin
    if (hit) begin
      first_word_o = {{(WORD_W - IDX_W){1'b0}}, idx};
    end else begin
      first_word_o = IDLE_CODE;
    end
  end

endmodule

// File: rtl/apb_irq_collector.sv
module apb_irq_collector
  import irqc_pkg::*;
#(
  parameter int unsigned SRC_COUNT = 40,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 pclk,
  input  logic                 presetn,
  input  logic                 psel,
  input  logic                 penable,
  input  logic                 pwrite,
  input  logic [ADDR_W-1:0]    paddr,
  input  logic [31:0]          pwdata,
  output logic [31:0]          prdata,
  output logic                 pready,
  output logic                 pslverr,
  input  logic [SRC_COUNT-1:0] irq_src_i,
  output logic                 irq_o
);

  logic               rst_sync_n;
  logic [31:0]        addr_ext;
  reg_sel_e           sel;
  logic               wr_stb;
  logic [MAX_SRC-1:0] raw_ext;
  logic [MAX_SRC-1:0] ena_q;
  logic [MAX_SRC-1:0] msk_q;
  logic [MAX_SRC-1:0] fstat;
  logic               fstat_any;
  logic [31:0]        first_word;
  logic               irq_q;
  logic               irq_d;
  logic               irq_we;

  irqc_rst_sync u_rst_sync (
    .clk         (pclk),
    .rst_async_n (presetn),
    .rst_sync_n  (rst_sync_n)
  );

  always_comb begin
    addr_ext = 32'(paddr);
    sel      = decode_offset(addr_ext);
    wr_stb   = psel && penable && pwrite;
  end

  always_comb begin
    raw_ext                = '0;
    raw_ext[SRC_COUNT-1:0] = irq_src_i;
  end

  irqc_ctrl_regs #(
    .SRC_COUNT (SRC_COUNT)
  ) u_ctrl_regs (
    .clk    (pclk),
    .rst_n  (rst_sync_n),
    .wr_stb (wr_stb),
    .wr_sel (sel),
    .wdata  (pwdata),
    .ena_q  (ena_q),
    .msk_q  (msk_q)
  );

  irqc_gate #(
    .SRC_COUNT (SRC_COUNT)
  ) u_gate (
    .raw_i  (raw_ext),
    .ena_i  (ena_q),
    .msk_i  (msk_q),
    .stat_o (fstat),
    .any_o  (fstat_any)
  );

  irqc_first_set u_first_set (
    .stat_i       (fstat),
    .first_word_o (first_word)
  );

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      case (sel)
        SEL_ENA_LO:  prdata = ena_q[31:0];
        SEL_ENA_HI:  prdata = ena_q[63:32];
        SEL_MSK_LO:  prdata = msk_q[31:0];
        SEL_MSK_HI:  prdata = msk_q[63:32];
        SEL_STAT_LO: prdata = fstat[31:0];
        SEL_STAT_HI: prdata = fstat[63:32];
        SEL_FIRST:   prdata = first_word;
        default:     prdata = '0;
      endcase
    end
  end

  always_comb begin
    irq_d  = fstat_any;
    irq_we = (irq_d != irq_q);
  end

  always_ff @(posedge pclk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_q <= 1'b0;
    end else if (irq_we) begin
      irq_q <= irq_d;
    end
  end

  assign irq_o   = irq_q;
  assign pready  = 1'b1;
  assign pslverr = 1'b0;

endmodule

// File: rtl/irqc_checker.sv
module irqc_checker
  import irqc_pkg::*;
#(
  parameter int unsigned SRC_COUNT = 40
) (
  input logic               clk,
  input logic               rst_n,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [MAX_SRC-1:0] raw_ext,
  input logic [MAX_SRC-1:0] ena_q,
  input logic [MAX_SRC-1:0] msk_q,
  input logic [MAX_SRC-1:0] fstat,
  input logic [31:0]        first_word,
  input logic               irq_o
);

  logic [MAX_SRC-1:0] below_mask;
  always_comb begin
    below_mask = (64'd1 << first_word[IDX_W-1:0]) - 64'd1;
  end

  AST_IRQ_RISE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (fstat != '0) |=> irq_o); // R6
  AST_IRQ_FALL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (fstat == '0) |=> !irq_o); // R6
  AST_STATUS_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (fstat & ~raw_ext) == '0); // R4
  AST_STATUS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (fstat & ~ena_q) == '0); // R4
  AST_STATUS_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (fstat & msk_q) == '0); // R3
  AST_FIRST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (fstat == '0) |-> (first_word == IDLE_CODE)); // R7
  AST_FIRST_POINTS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (fstat != '0) |-> (fstat[first_word[IDX_W-1:0]] && ((fstat & below_mask) == '0)
                       && (first_word[31:IDX_W] == '0))); // R7
  AST_CFG_HOLDS_OFF_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(psel && penable && pwrite) |=> ($stable(ena_q) && $stable(msk_q))); // R10

endmodule

bind apb_irq_collector irqc_checker #(
  .SRC_COUNT (SRC_COUNT)
) u_irqc_checker (
  .clk        (pclk),
  .rst_n      (rst_sync_n),
  .psel       (psel),
  .penable    (penable),
  .pwrite     (pwrite),
  .raw_ext    (raw_ext),
  .ena_q      (ena_q),
  .msk_q      (msk_q),
  .fstat      (fstat),
  .first_word (first_word),
  .irq_o      (irq_o)
);

// File: tb/test_apb_irq_collector.sv
module test_apb_irq_collector;

  localparam int unsigned NSRC   = 40;
  localparam int unsigned AW     = 8;
  localparam logic [63:0] IMPL   = (64'd1 << NSRC) - 64'd1;
  localparam int unsigned NVEC   = 6;

  // fields: line levels[191:128], ena lo[127:96], ena hi[95:64], msk lo[63:32], msk hi[31:0]
  localparam logic [191:0] VEC [NVEC] = '{
    {64'h0000_0000_0000_0000, 32'hFFFF_FFFF, 32'h0000_00FF, 32'h0000_0000, 32'h0000_0000},
    {64'h0000_0000_0000_0001, 32'h0000_0001, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000},
    {64'h0000_00FF_FFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_00FF, 32'h0000_FFFF, 32'h0000_0000},
    {64'h0000_0080_0000_0000, 32'h0000_0000, 32'h0000_0080, 32'h0000_0000, 32'h0000_0000},
    {64'hFFFF_FFFF_FFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_000F},
    {64'h0000_0012_8000_0000, 32'h0000_0000, 32'h0000_00FF, 32'h0000_0000, 32'h0000_0000}
  };

  logic            pclk;
  logic            presetn;
  logic            psel;
  logic            penable;
  logic            pwrite;
  logic [AW-1:0]   paddr;
  logic [31:0]     pwdata;
  logic [31:0]     prdata;
  logic            pready;
  logic            pslverr;
  logic [NSRC-1:0] irq_src_i;
  logic            irq_o;

  int n_chk  = 0;
  int n_fail = 0;

  apb_irq_collector #(.SRC_COUNT(NSRC), .ADDR_W(AW)) i_apb_irq_collector (
    .pclk      (pclk),
    .presetn   (presetn),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .pready    (pready),
    .pslverr   (pslverr),
    .irq_src_i (irq_src_i),
    .irq_o     (irq_o)
  );

  initial pclk = 1'b0;
  always #4 pclk = ~pclk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [7:0] addr, input logic [31:0] data);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = addr; pwdata = data;
    @(negedge pclk);
    penable = 1'b1;
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic apb_read(input logic [7:0] addr, output logic [31:0] data);
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = addr;
    @(negedge pclk);
    penable = 1'b1;
    #1;
    data = prdata;
    check("R9 pready", {31'd0, pready}, 32'd1);
    check("R9 pslverr", {31'd0, pslverr}, 32'd0);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic read_check(input string req, input logic [7:0] addr, input logic [31:0] exp);
    logic [31:0] d;
    apb_read(addr, d);
    check(req, d, exp);
  endtask

  function automatic logic [31:0] first_code(input logic [63:0] st);
    logic [31:0] r;
    r = 32'h8000_0000;
    for (int i = 63; i >= 0; i--) begin
      if (st[i]) r = 32'(i);
    end
    return r;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge pclk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [63:0] st;
    logic [31:0] d;
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; irq_src_i = '0;
    presetn = 1'b0;
    repeat (3) @(negedge pclk);
    #1;
    check("R1 irq_o in reset", {31'd0, irq_o}, 32'd0);
    presetn = 1'b1;
    repeat (4) @(negedge pclk);

    // R1 reset values
    read_check("R1 ena lo", 8'h00, 32'h0);
    read_check("R1 ena hi", 8'h04, 32'h0);
    read_check("R1 msk lo", 8'h08, 32'h0);
    read_check("R1 msk hi", 8'h0C, 32'h0);
    read_check("R1 stat lo", 8'h30, 32'h0);
    read_check("R1 stat hi", 8'h34, 32'h0);
    read_check("R1 first", 8'h40, 32'h8000_0000);
    check("R1 irq_o", {31'd0, irq_o}, 32'd0);

    // Vector table: R4 R7 R6
    for (int v = 0; v < NVEC; v++) begin
      logic [191:0] rec;
      logic [63:0]  ena, msk, raw;
      rec = VEC[v];
      raw = rec[191:128] & IMPL;
      ena = {rec[95:64], rec[127:96]} & IMPL;
      msk = {rec[31:0], rec[63:32]} & IMPL;
      st  = raw & ena & ~msk;
      apb_write(8'h00, rec[127:96]);
      apb_write(8'h04, rec[95:64]);
      apb_write(8'h08, rec[63:32]);
      apb_write(8'h0C, rec[31:0]);
      @(negedge pclk);
      irq_src_i = rec[128 +: NSRC];
      read_check($sformatf("R4 vec%0d stat lo", v), 8'h30, st[31:0]);
      read_check($sformatf("R4 vec%0d stat hi", v), 8'h34, st[63:32]);
      read_check($sformatf("R7 vec%0d first", v), 8'h40, first_code(st));
      check($sformatf("R6 vec%0d irq_o", v), {31'd0, irq_o}, {31'd0, |st});
    end

    // R2 / R3 readback and unimplemented positions
    apb_write(8'h00, 32'hFFFF_FFFF);
    apb_write(8'h04, 32'hFFFF_FFFF);
    read_check("R2 ena lo all ones", 8'h00, 32'hFFFF_FFFF);
    read_check("R2 ena hi unimplemented zero", 8'h04, 32'h0000_00FF);
    apb_write(8'h08, 32'hA5A5_5A5A);
    apb_write(8'h0C, 32'hFFFF_FFFF);
    read_check("R3 msk lo", 8'h08, 32'hA5A5_5A5A);
    read_check("R3 msk hi unimplemented zero", 8'h0C, 32'h0000_00FF);
    apb_write(8'h08, 32'h0);
    apb_write(8'h0C, 32'h0);

    // R6 one-cycle latency, R5 level following
    @(negedge pclk);
    irq_src_i = '0;
    repeat (2) @(negedge pclk);
    check("R6 idle irq_o", {31'd0, irq_o}, 32'd0);
    irq_src_i = NSRC'(64'h0000_0000_0000_0100);
    #1;
    check("R6 irq_o not yet", {31'd0, irq_o}, 32'd0);
    @(negedge pclk);
    check("R6 irq_o after one edge", {31'd0, irq_o}, 32'd1);
    read_check("R5 stat while high", 8'h30, 32'h0000_0100);
    read_check("R7 first bit8", 8'h40, 32'd8);
    @(negedge pclk);
    irq_src_i = '0;
    #1;
    read_check("R5 stat clears with line", 8'h30, 32'h0);
    check("R6 irq_o falls", {31'd0, irq_o}, 32'd0);

    // R8 unlisted offsets and writes to read-only offsets
    read_check("R8 unlisted 0x10", 8'h10, 32'h0);
    read_check("R8 unlisted 0x3C", 8'h3C, 32'h0);
    read_check("R8 unlisted 0x44", 8'h44, 32'h0);
    read_check("R8 misaligned 0x02", 8'h02, 32'h0);
    @(negedge pclk);
    irq_src_i = NSRC'(64'h0000_0001_0000_0000);
    apb_write(8'h30, 32'h0);
    apb_write(8'h34, 32'h0);
    apb_write(8'h40, 32'h0);
    apb_write(8'h10, 32'h0);
    apb_write(8'h02, 32'h0);
    read_check("R8 ena lo after ro writes", 8'h00, 32'hFFFF_FFFF);
    read_check("R8 ena hi after ro writes", 8'h04, 32'h0000_00FF);
    read_check("R8 msk lo after ro writes", 8'h08, 32'h0);
    read_check("R8 stat hi kept", 8'h34, 32'h0000_0001);
    read_check("R7 first bit32", 8'h40, 32'd32);

    // R10 setup phase alone writes nothing
    @(negedge pclk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 8'h00; pwdata = 32'h0;
    repeat (3) @(negedge pclk);
    psel = 1'b0; pwrite = 1'b0;
    read_check("R10 ena lo after setup only", 8'h00, 32'hFFFF_FFFF);
    @(negedge pclk);
    psel = 1'b0; penable = 1'b1; pwrite = 1'b1; paddr = 8'h04; pwdata = 32'h0;
    repeat (2) @(negedge pclk);
    penable = 1'b0; pwrite = 1'b0;
    read_check("R10 ena hi without select", 8'h04, 32'h0000_00FF);

    // R3 mask suppresses a pending line
    apb_write(8'h0C, 32'h0000_0001);
    read_check("R3 masked stat hi", 8'h34, 32'h0);
    read_check("R3 masked first idle", 8'h40, 32'h8000_0000);
    apb_read(8'h0C, d);
    check("R3 mask readback", d, 32'h1);
    check("R6 irq_o masked", {31'd0, irq_o}, 32'd0);

    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule